// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block supervises software liveness. A processor toggles a general-purpose line, the kick input, and every transition on that line, rising or falling, restarts a millisecond counter. If the counter reaches the selected timeout before another transition arrives, the block emits a single-cycle expiry pulse. A separate reset sequencer turns that pulse into assertion of both system resets. The timebase is a one-cycle `msTick` strobe that arrives once per millisecond.

The kick line is asynchronous. It passes through a two-flop synchroniser and an edge register, so a transition takes effect on the third rising clock edge after it changes. Two inputs from the reset sequencer control arming. While the peripheral reset is active, the watchdog is idle and kicks have no effect. A release pulse, issued when that reset goes inactive, arms the watchdog with the counter at zero. After an expiry the watchdog stays idle until the next release pulse. The 2-bit timeout select is read once after power-on reset and held from then on. Driving the enable input low keeps the counter at zero and blocks any expiry.

Top module: `wdt_edge_kick`

## Requirements
- R1: A rising edge on `kickIn` clears the elapsed count, and so does a falling edge. After either one, a full timeout of ticks is needed before expiry.
- R2: The timeout in `msTick` pulses follows the captured select: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 5 and 2'b11 gives 10.
- R3: `toutSel` is sampled on the first rising clock edge after `rstN` goes high. Later changes on it have no effect until the next reset.
- R4: When armed and enabled with no kick, `expirePulse` goes high for exactly one clock cycle. It rises on the edge that samples the Nth `msTick` since the last restart, where N is the selected timeout.
- R5: While `periphRstActive` is high, kicks and ticks are ignored and `expirePulse` stays low. The watchdog is disarmed during that time.
- R6: A `periphRelease` pulse arms the watchdog and clears the count, including when the watchdog is already armed and counting.
- R7: While `wdEnable` is low, no expiry is produced and the count is held at zero. After enable returns high, a full timeout is needed before expiry.
- R8: After power-on reset, and after each expiry, the watchdog is idle and produces no expiry until a `periphRelease` pulse arrives.
- R9: While `rstN` is low, `expirePulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| kickIn | input | 1 | Asynchronous kick line; any transition is a kick |
| wdEnable | input | 1 | High enables the watchdog; low disables expiry |
| toutSel | input | 2 | Timeout select, captured once after reset |
| msTick | input | 1 | One-cycle millisecond timebase strobe |
| periphRstActive | input | 1 | High while the peripheral reset is asserted |
| periphRelease | input | 1 | One-cycle pulse when the peripheral reset releases |
| expirePulse | output | 1 | One-cycle pulse on watchdog timeout |

## Verification
The hardest case to reach is a count that is partly used up when a disarming event occurs: a reset, a re-release or a disable in the middle of a count. The block has to discard that partial count, not carry it forward. The stimulus first advances the counter by a few ticks while armed. It then applies the event, sends kicks while the reset is active, and afterwards counts ticks one at a time. This shows that expiry falls exactly N ticks after the restart, not earlier. Kicks are placed four clocks ahead of the next tick to cover the synchroniser latency.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic captureSel;
    logic clearCount;
    logic stepCount;
  } wdtStrobe_t;

  typedef enum logic {
    WDT_IDLE  = 1'b0,
    WDT_ARMED = 1'b1
  } wdtState_t;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic kickIn,
  output logic kickEdge
);

  // stages 0..SYNC_STAGES-1 resynchronise, the last stage holds the previous level
  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= 1'b0;
    else       pipe[0] <= kickIn;
  end

  for (genvar s = 1; s <= SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= 1'b0;
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign kickEdge = pipe[SYNC_STAGES] ^ pipe[SYNC_STAGES-1];

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       kickEdge,
  input  logic       wdEnable,
  input  logic       msTick,
  input  logic       periphRstActive,
  input  logic       periphRelease,
  input  logic       atLast,
  output wdtStrobe_t strobe,
  output logic       expirePulse,
  output logic       selValid
);

  wdtState_t state, nextState;
  logic      fireNext;

  always_comb begin
    strobe            = '0;
    strobe.captureSel = !selValid;
    nextState         = state;
    fireNext          = 1'b0;
    if (periphRelease) begin
      strobe.clearCount = 1'b1;
      nextState         = WDT_ARMED;
    end else if (periphRstActive || state == WDT_IDLE) begin
      strobe.clearCount = 1'b1;
      nextState         = WDT_IDLE;
    end else if (!wdEnable || kickEdge) begin
      strobe.clearCount = 1'b1;
    end else if (msTick) begin
      if (atLast) begin
        strobe.clearCount = 1'b1;
        fireNext          = 1'b1;
        nextState         = WDT_IDLE;
      end else begin
        strobe.stepCount = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= WDT_IDLE;
      expirePulse <= 1'b0;
      selValid    <= 1'b0;
    end else begin
      state       <= nextState;
      expirePulse <= fireNext;
      selValid    <= 1'b1;
    end
  end

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int TOUT_SEL0 = 1,
  parameter int TOUT_SEL1 = 2,
  parameter int TOUT_SEL2 = 5,
  parameter int TOUT_SEL3 = 10,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strobe,
  input  logic [1:0]       toutSel,
  output logic             atLast,
  output logic [CNT_W-1:0] tickCount,
  output logic [CNT_W-1:0] curLimit,
  output logic [1:0]       selHeld
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 selHeld <= 2'b00;
    else if (strobe.captureSel) selHeld <= toutSel;
  end

  always_comb begin
    unique case (selHeld)
      2'b00:   curLimit = CNT_W'(TOUT_SEL0);
      2'b01:   curLimit = CNT_W'(TOUT_SEL1);
      2'b10:   curLimit = CNT_W'(TOUT_SEL2);
      default: curLimit = CNT_W'(TOUT_SEL3);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  tickCount <= '0;
    else if (strobe.clearCount) tickCount <= '0;
    else if (strobe.stepCount)  tickCount <= tickCount + 1'b1;
  end

  assign atLast = (tickCount == curLimit - 1'b1);

endmodule

// File: rtl/wdt_edge_kick.sv
module wdt_edge_kick
  import wdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TOUT_SEL0   = 1,
  parameter int TOUT_SEL1   = 2,
  parameter int TOUT_SEL2   = 5,
  parameter int TOUT_SEL3   = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       kickIn,
  input  logic       wdEnable,
  input  logic [1:0] toutSel,
  input  logic       msTick,
  input  logic       periphRstActive,
  input  logic       periphRelease,
  output logic       expirePulse
);

  localparam int MAX_TOUT = maxOf4(TOUT_SEL0, TOUT_SEL1, TOUT_SEL2, TOUT_SEL3);
  localparam int CNT_W    = $clog2(MAX_TOUT + 1);

  logic             kickEdge;
  logic             atLast;
  logic             selValid;
  logic [1:0]       selHeld;
  logic [CNT_W-1:0] tickCount;
  logic [CNT_W-1:0] curLimit;
  wdtStrobe_t       strobe;

  wdt_kick_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rstN     (rstN),
    .kickIn   (kickIn),
    .kickEdge (kickEdge)
  );

  wdt_ctrl i_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .kickEdge        (kickEdge),
    .wdEnable        (wdEnable),
    .msTick          (msTick),
    .periphRstActive (periphRstActive),
    .periphRelease   (periphRelease),
    .atLast          (atLast),
    .strobe          (strobe),
    .expirePulse     (expirePulse),
    .selValid        (selValid)
  );

  wdt_datapath #(
    .TOUT_SEL0 (TOUT_SEL0),
    .TOUT_SEL1 (TOUT_SEL1),
    .TOUT_SEL2 (TOUT_SEL2),
    .TOUT_SEL3 (TOUT_SEL3),
    .CNT_W     (CNT_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .toutSel   (toutSel),
    .atLast    (atLast),
    .tickCount (tickCount),
    .curLimit  (curLimit),
    .selHeld   (selHeld)
  );

endmodule

// File: rtl/wdt_edge_kick_chk.sv
module wdt_edge_kick_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             wdEnable,
  input logic             msTick,
  input logic             periphRstActive,
  input logic             periphRelease,
  input logic             expirePulse,
  input logic             selValid,
  input logic [1:0]       selHeld,
  input logic [CNT_W-1:0] tickCount,
  input logic [CNT_W-1:0] curLimit
);

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |=> !expirePulse);

  a_r4_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |-> $past(msTick));

  a_r7_quiet_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable |=> !expirePulse);

  a_r5_quiet_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    (periphRstActive && !periphRelease) |=> !expirePulse);

  a_r2_count_below_limit: assert property (@(posedge clk) disable iff (!rstN)
    tickCount < curLimit);

  a_r3_sel_held: assert property (@(posedge clk) disable iff (!rstN)
    selValid |=> $stable(selHeld));

endmodule

bind wdt_edge_kick wdt_edge_kick_chk #(.CNT_W(CNT_W)) i_chk (
  .clk             (clk),
  .rstN            (rstN),
  .wdEnable        (wdEnable),
  .msTick          (msTick),
  .periphRstActive (periphRstActive),
  .periphRelease   (periphRelease),
  .expirePulse     (expirePulse),
  .selValid        (selValid),
  .selHeld         (selHeld),
  .tickCount       (tickCount),
  .curLimit        (curLimit)
);

// File: tb/test_wdt_edge_kick.sv
`timescale 1ns/1ps
module test_wdt_edge_kick;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       kickIn = 1'b0;
  logic       wdEnable = 1'b1;
  logic [1:0] toutSel = 2'b00;
  logic       msTick = 1'b0;
  logic       periphRstActive = 1'b0;
  logic       periphRelease = 1'b0;
  logic       expirePulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam int NVEC = 4;
  localparam logic [1:0] VEC_SEL [NVEC] = '{2'b10, 2'b00, 2'b11, 2'b01};
  localparam int         VEC_LIM [NVEC] = '{5, 1, 10, 2};

  always #5 clk = ~clk;

  wdt_edge_kick i_wdt_edge_kick (
    .clk             (clk),
    .rstN            (rstN),
    .kickIn          (kickIn),
    .wdEnable        (wdEnable),
    .toutSel         (toutSel),
    .msTick          (msTick),
    .periphRstActive (periphRstActive),
    .periphRelease   (periphRelease),
    .expirePulse     (expirePulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic resetDut(input logic [1:0] sel);
    @(negedge clk);
    rstN = 1'b0;
    toutSel = sel;
    periphRelease = 1'b0;
    periphRstActive = 1'b0;
    msTick = 1'b0;
    repeat (3) @(negedge clk);
    check(expirePulse == 1'b0, "R9", int'(expirePulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    toutSel = ~sel;  // later changes must not matter (R3)
    repeat (3) @(negedge clk);
  endtask

  task automatic releasePulse();
    @(negedge clk);
    periphRstActive = 1'b0;
    periphRelease = 1'b1;
    @(negedge clk);
    periphRelease = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk);
    kickIn = ~kickIn;
    repeat (4) @(negedge clk);
  endtask

  // issues n ticks, returns how many of them produced an expiry
  task automatic runTicks(input int n, output int fires);
    fires = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      msTick = 1'b1;
      @(negedge clk);
      msTick = 1'b0;
      if (expirePulse) begin
        fires++;
        @(negedge clk);
        check(expirePulse == 1'b0, "R4 single cycle", int'(expirePulse), 0);
      end
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f;
    // R9 reset state and R8 idle before first release
    resetDut(2'b00);
    runTicks(15, f);
    check(f == 0, "R8 idle before release", f, 0);

    // table of select values: R2, R3, R1, R4, R8
    for (int v = 0; v < NVEC; v++) begin
      resetDut(VEC_SEL[v]);
      releasePulse();
      runTicks(VEC_LIM[v] - 1, f);
      check(f == 0, "R2 early", f, 0);
      kick();
      runTicks(VEC_LIM[v] - 1, f);
      check(f == 0, "R1 after kick", f, 0);
      runTicks(1, f);
      check(f == 1, "R2 R3 expiry at limit", f, 1);
      runTicks(12, f);
      check(f == 0, "R8 idle after expiry", f, 0);
    end

    // R1 both edge directions within one run
    resetDut(2'b11);
    releasePulse();
    runTicks(8, f);
    kick();
    runTicks(8, f);
    kick();
    runTicks(9, f);
    check(f == 0, "R1 rising and falling kicks", f, 0);
    runTicks(1, f);
    check(f == 1, "R1 expiry after last kick", f, 1);

    // R7 disable holds count at zero
    resetDut(2'b01);
    releasePulse();
    runTicks(1, f);
    @(negedge clk);
    wdEnable = 1'b0;
    runTicks(20, f);
    check(f == 0, "R7 no expiry while disabled", f, 0);
    @(negedge clk);
    wdEnable = 1'b1;
    runTicks(1, f);
    check(f == 0, "R7 count cleared while disabled", f, 0);
    runTicks(1, f);
    check(f == 1, "R7 expiry after re-enable", f, 1);

    // R5 kicks ignored while reset active, R6 restart from zero
    resetDut(2'b10);
    releasePulse();
    runTicks(3, f);
    @(negedge clk);
    periphRstActive = 1'b1;
    kick();
    kick();
    runTicks(15, f);
    check(f == 0, "R5 no expiry during reset", f, 0);
    releasePulse();
    runTicks(4, f);
    check(f == 0, "R6 restart from zero", f, 0);
    runTicks(1, f);
    check(f == 1, "R6 expiry after release", f, 1);

    // R6 release while already armed restarts count
    resetDut(2'b11);
    releasePulse();
    runTicks(7, f);
    releasePulse();
    runTicks(9, f);
    check(f == 0, "R6 re-release clears count", f, 0);
    runTicks(1, f);
    check(f == 1, "R6 expiry after re-release", f, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule